// File: doc/BRIEF.md
# Supervised Reset Release Generator

This block turns digitized supply-monitor outputs and an external reset pin into a single active-low chip reset. Two comparator flags describe the supply. One is true above a lower "assert" level and the other is true above a higher "release" level, so the gap between them forms hysteresis. A third flag reports a supply sag. A runtime bit decides whether that sag is allowed to reset the chip.

Reset is held until the supply has stayed above the release level for a parameterized number of clock cycles. That hold-off can be sized to cover the slowest peripheral's start-up time, for example 25,000,000 cycles, which is 100 ms at 250 MHz. A low pulse on the external pin resets the chip only when it lasts at least a parameterized number of cycles. Any new reset assertion is reported by a one-cycle event that carries its cause.

The lower supply flag clears the block asynchronously, so reset asserts at once when the supply collapses. Every other input passes through a two-flop synchronizer, and reset is always released on a clock edge.

Top module: `reset_release_gen`

## Requirements
- R1: After `sup_above_lo` and `sup_above_hi` rise together, between two clock edges, `rst_out_n` stays low through rising edge HOLD_CYC+3 after the change and goes high on edge HOLD_CYC+4.
- R2: With `sup_above_lo` high, a low `sup_above_hi` has no effect while reset is released. During hold-off it keeps reset asserted and restarts the count. If `sup_above_hi` rises D≥2 cycles after `sup_above_lo`, reset is low for D+1+HOLD_CYC sampled cycles.
- R3: While `sup_above_lo` is low, `rst_out_n` is low, with no clock edge needed. It also stays low for at least the first three edges after `sup_above_lo` returns.
- R4: With `sag_en` high, a `sag_det` pulse of B cycles drives `rst_out_n` low from the third edge of the pulse. Reset is released after a fresh hold-off, for B+HOLD_CYC-1 low cycles in all.
- R5: With `sag_en` low, `sag_det` has no effect on `rst_out_n`.
- R6: An `ext_rst_n` low pulse of W≥PIN_MIN_CYC cycles asserts reset. Reset stays low while the pin is low and then for a full hold-off, for W+HOLD_CYC-PIN_MIN_CYC low cycles in all.
- R7: An `ext_rst_n` low pulse shorter than PIN_MIN_CYC cycles has no effect on `rst_out_n` or `rst_evt`.
- R8: `rst_evt` pulses for exactly one cycle on each new reset assertion. The cause codes are 1 for power-on (issued once each time `sup_above_lo` returns), 2 for supply sag and 3 for the pin. A sag or pin trip while reset is already held produces no event. Sag wins over pin when both trip together.
- R9: `rst_out_n` is active-low. It rises only on a clock edge, after at least HOLD_CYC consecutive low cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| sup_above_lo | input | 1 | Supply above the lower (assert) level; low clears the block asynchronously |
| sup_above_hi | input | 1 | Supply above the upper (release) level |
| sag_det | input | 1 | Supply sag comparator output, high on sag |
| sag_en | input | 1 | Runtime enable for sag-triggered reset |
| ext_rst_n | input | 1 | External reset pin, active-low |
| rst_out_n | output | 1 | Chip reset, active-low |
| rst_evt | output | 1 | One-cycle pulse on each new reset assertion |
| rst_evt_cause | output | 2 | Cause of the assertion flagged by `rst_evt` |

## Verification
Both supply flags are first raised together, and then the release level is raised late, which separates a fixed release latency from a count that waits on `sup_above_hi`. Dropping `sup_above_lo` in the running state and again in mid hold-off shows that reset asserts asynchronously and that the count restarts from zero. Sag pulses are applied with the enable both on and off, and pin pulses of one cycle below, exactly at and well above the minimum width are applied. Together these show the filter boundary and the formula for the low time. A scoreboard pairs every cause event and every measured low-time with the value predicted from the requirements.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_POWER = 2'd1,
      CAUSE_SAG   = 2'd2,
      CAUSE_PIN   = 2'd3
   } rst_cause_e;

   typedef enum logic {
      ST_HOLD = 1'b0,
      ST_RUN  = 1'b1
   } hold_state_e;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
   parameter int          W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [1:0] stage;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) stage <= {2{RST_VAL[i]}};
         else         stage <= {stage[0], d[i]};
      end
      assign q[i] = stage[1];
   end
endmodule

// File: rtl/rstgen_pin_filter.sv
module rstgen_pin_filter #(
   parameter int MIN_CYC = 64
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pin_n_s,
   output logic trip
);
   if (MIN_CYC < 1) begin : g_bad_min
      $error("rstgen_pin_filter: MIN_CYC must be at least 1");
   end

   if (MIN_CYC == 1) begin : g_direct
      assign trip = ~pin_n_s;
   end else begin : g_count
      localparam int CW = $clog2(MIN_CYC + 1);
      localparam logic [CW-1:0] TOP = CW'(MIN_CYC);
      logic [CW-1:0] low_run;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)           low_run <= '0;
         else if (pin_n_s)      low_run <= '0;
         else if (low_run != TOP) low_run <= low_run + 1'b1;
      end
      assign trip = (low_run == TOP);
   end
endmodule

// File: rtl/rstgen_holdoff.sv
module rstgen_holdoff
   import rstgen_pkg::*;
#(
   parameter int HOLD_CYC = 25_000_000
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       above_hi,
   input  logic       sag_trip,
   input  logic       pin_trip,
   output logic       released,
   output logic       evt_vld,
   output rst_cause_e evt_cause
);
   localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

   hold_state_e   st;
   logic [CW-1:0] cnt;
   logic          power_pend;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st         <= ST_HOLD;
         cnt        <= '0;
         power_pend <= 1'b1;
         evt_vld    <= 1'b0;
         evt_cause  <= CAUSE_NONE;
      end else begin
         evt_vld   <= 1'b0;
         evt_cause <= CAUSE_NONE;
         if (power_pend) begin
            power_pend <= 1'b0;
            evt_vld    <= 1'b1;
            evt_cause  <= CAUSE_POWER;
         end
         if (sag_trip || pin_trip) begin
            cnt <= '0;
            st  <= ST_HOLD;
            if (st == ST_RUN) begin
               evt_vld   <= 1'b1;
               evt_cause <= sag_trip ? CAUSE_SAG : CAUSE_PIN;
            end
         end else if (st == ST_HOLD) begin
            if (!above_hi) begin
               cnt <= '0;
            end else if (cnt == LAST) begin
               cnt <= '0;
               st  <= ST_RUN;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign released = (st == ST_RUN);
endmodule

// File: rtl/reset_release_gen.sv
module reset_release_gen
   import rstgen_pkg::*;
#(
   parameter int HOLD_CYC    = 25_000_000,
   parameter int PIN_MIN_CYC = 64
) (
   input  logic       clk,
   input  logic       sup_above_lo,
   input  logic       sup_above_hi,
   input  logic       sag_det,
   input  logic       sag_en,
   input  logic       ext_rst_n,
   output logic       rst_out_n,
   output logic       rst_evt,
   output logic [1:0] rst_evt_cause
);
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("reset_release_gen: HOLD_CYC must be at least 1");
   end

   localparam int NSYNC = 4;
   localparam logic [NSYNC-1:0] SYNC_RST = 4'b1000;

   // Local reset: cleared at once by the low supply flag, released on clk.
   logic [1:0] lrst_q;
   logic       lrst_n;
   always_ff @(posedge clk or negedge sup_above_lo) begin
      if (!sup_above_lo) lrst_q <= 2'b00;
      else               lrst_q <= {lrst_q[0], 1'b1};
   end
   assign lrst_n = lrst_q[1];

   logic [NSYNC-1:0] raw_in, syn_in;
   assign raw_in = {ext_rst_n, sag_en, sag_det, sup_above_hi};

   rstgen_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
      .clk    (clk),
      .arst_n (lrst_n),
      .d      (raw_in),
      .q      (syn_in)
   );

   logic hi_s, sag_s, sag_en_s, pin_n_s;
   assign {pin_n_s, sag_en_s, sag_s, hi_s} = syn_in;

   logic pin_trip, sag_trip;
   assign sag_trip = sag_s & sag_en_s;

   rstgen_pin_filter #(.MIN_CYC(PIN_MIN_CYC)) u_pin (
      .clk     (clk),
      .arst_n  (lrst_n),
      .pin_n_s (pin_n_s),
      .trip    (pin_trip)
   );

   rst_cause_e cause_q;
   logic       released;

   rstgen_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk       (clk),
      .arst_n    (lrst_n),
      .above_hi  (hi_s),
      .sag_trip  (sag_trip),
      .pin_trip  (pin_trip),
      .released  (released),
      .evt_vld   (rst_evt),
      .evt_cause (cause_q)
   );

   assign rst_out_n     = released;
   assign rst_evt_cause = cause_q;
endmodule

// File: rtl/reset_release_gen_chk.sv
module reset_release_gen_chk #(
   parameter int HOLD_CYC    = 25_000_000,
   parameter int PIN_MIN_CYC = 64
) (
   input logic       clk,
   input logic       sup_above_lo,
   input logic       sag_det,
   input logic       sag_en,
   input logic       ext_rst_n,
   input logic       rst_out_n,
   input logic       rst_evt,
   input logic [1:0] rst_evt_cause
);
   localparam int LW = $clog2(HOLD_CYC + 1);
   localparam int PW = $clog2(PIN_MIN_CYC + 1);
   localparam logic [LW-1:0] LTOP = LW'(HOLD_CYC);
   localparam logic [PW-1:0] PTOP = PW'(PIN_MIN_CYC);

   logic [LW-1:0] low_run;
   logic [PW-1:0] pin_run;
   logic          pin_long;
   logic [2:0]    up_cnt;

   always_ff @(posedge clk or negedge sup_above_lo) begin
      if (!sup_above_lo) begin
         low_run  <= '0;
         pin_run  <= '0;
         pin_long <= 1'b0;
         up_cnt   <= '0;
      end else begin
         if (up_cnt != 3'd7) up_cnt <= up_cnt + 1'b1;
         if (rst_out_n)            low_run <= '0;
         else if (low_run != LTOP) low_run <= low_run + 1'b1;
         if (ext_rst_n)            pin_run <= '0;
         else if (pin_run != PTOP) pin_run <= pin_run + 1'b1;
         if (rst_evt)              pin_long <= 1'b0;
         else if (pin_run == PTOP) pin_long <= 1'b1;
      end
   end

   AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!sup_above_lo)
      $rose(rst_out_n) |-> (low_run == LTOP)); // R9

   AST_HELD_AFTER_POWER: assert property (@(posedge clk) disable iff (!sup_above_lo)
      (up_cnt < 3'd3) |-> !rst_out_n); // R3

   AST_SAG_ASSERTS: assert property (@(posedge clk) disable iff (!sup_above_lo)
      ((up_cnt >= 3'd5) && sag_en && sag_det && $past(sag_en) && $past(sag_det)
       && $past(sag_en, 2) && $past(sag_det, 2)) |=> !rst_out_n); // R4

   AST_PIN_WIDTH_MET: assert property (@(posedge clk) disable iff (!sup_above_lo)
      (rst_evt && rst_evt_cause == 2'd3) |-> (pin_long || pin_run == PTOP)); // R7

   AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!sup_above_lo)
      rst_evt |=> !rst_evt); // R8

   AST_EVENT_CODED: assert property (@(posedge clk) disable iff (!sup_above_lo)
      rst_evt |-> (rst_evt_cause != 2'd0)); // R8
endmodule

bind reset_release_gen reset_release_gen_chk #(
   .HOLD_CYC    (HOLD_CYC),
   .PIN_MIN_CYC (PIN_MIN_CYC)
) u_chk (.*);

// File: tb/tb_reset_release_gen.sv
`timescale 1ns/1ps
module tb_reset_release_gen;
   localparam int H = 20;
   localparam int M = 4;

   logic       clk = 1'b0;
   logic       lo = 1'b0, hi = 1'b0, sag = 1'b0, sag_en = 1'b0, pin_n = 1'b1;
   logic       rst_out_n, rst_evt;
   logic [1:0] rst_evt_cause;

   int    n_vec = 0;
   int    n_bad = 0;
   int    low_cnt = 0;
   int    cause_q[$];
   int    len_q[$];
   string len_tag_q[$];

   always #2 clk = ~clk;

   reset_release_gen #(.HOLD_CYC(H), .PIN_MIN_CYC(M)) dut (
      .clk           (clk),
      .sup_above_lo  (lo),
      .sup_above_hi  (hi),
      .sag_det       (sag),
      .sag_en        (sag_en),
      .ext_rst_n     (pin_n),
      .rst_out_n     (rst_out_n),
      .rst_evt       (rst_evt),
      .rst_evt_cause (rst_evt_cause)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_evt(input int cause);
      cause_q.push_back(cause);
   endtask

   task automatic expect_len(input int len, input string tag);
      len_q.push_back(len);
      len_tag_q.push_back(tag);
   endtask

   // Monitor: sample just after each rising edge.
   always @(posedge clk) begin
      #1;
      if (rst_evt) begin
         if (cause_q.size() == 0) chk(1'b0, "R8 unexpected event", int'(rst_evt_cause), 0);
         else begin
            int e;
            e = cause_q.pop_front();
            chk(int'(rst_evt_cause) == e, "R8 event cause", int'(rst_evt_cause), e);
         end
      end
      if (!lo) low_cnt = 0;
      else if (!rst_out_n) low_cnt++;
      else if (low_cnt > 0) begin
         if (len_q.size() == 0) chk(1'b0, "R1 unexpected release", low_cnt, 0);
         else begin
            int    e;
            string t;
            e = len_q.pop_front();
            t = len_tag_q.pop_front();
            chk(low_cnt == e, t, low_cnt, e);
         end
         low_cnt = 0;
      end
   end

   initial begin
      cyc(3);
      chk(rst_out_n == 1'b0, "R3 reset state output", int'(rst_out_n), 0);
      chk(rst_evt == 1'b0, "R8 reset state event", int'(rst_evt), 0);

      // R1: both supply flags rise together
      expect_evt(1); expect_len(H + 3, "R1 power-up hold length");
      lo = 1'b1; hi = 1'b1;
      cyc(H + 10);
      chk(rst_out_n == 1'b1, "R1 released", int'(rst_out_n), 1);

      // R2: release level lost while running, no effect
      hi = 1'b0;
      for (int i = 0; i < 8; i++) begin
         cyc(4);
         chk(rst_out_n == 1'b1, "R2 hysteresis while running", int'(rst_out_n), 1);
      end
      hi = 1'b1; cyc(5);

      // R5: sag with enable off
      sag = 1'b1; cyc(10);
      chk(rst_out_n == 1'b1, "R5 sag ignored when disabled", int'(rst_out_n), 1);
      sag = 1'b0; cyc(5);

      // R4: sag with enable on, pulse of 5 cycles
      sag_en = 1'b1; cyc(4);
      expect_evt(2); expect_len(5 + H - 1, "R4 sag hold length");
      sag = 1'b1; cyc(5); sag = 1'b0;
      cyc(H + 10);
      chk(rst_out_n == 1'b1, "R4 released after sag", int'(rst_out_n), 1);

      // R7: pin pulse one cycle short of the minimum
      pin_n = 1'b0; cyc(M - 1); pin_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         cyc(3);
         chk(rst_out_n == 1'b1, "R7 short pin pulse ignored", int'(rst_out_n), 1);
      end

      // R6: pin pulse exactly at the minimum
      expect_evt(3); expect_len(H, "R6 pin hold length at minimum");
      pin_n = 1'b0; cyc(M); pin_n = 1'b1;
      cyc(H + 10);

      // R6: long pin pulse
      expect_evt(3); expect_len(10 + H - M, "R6 pin hold length long pulse");
      pin_n = 1'b0; cyc(10); pin_n = 1'b1;
      cyc(H + 10);
      chk(rst_out_n == 1'b1, "R6 released after pin", int'(rst_out_n), 1);

      // R3: supply collapse while running asserts without a clock edge
      lo = 1'b0; hi = 1'b0;
      #1;
      chk(rst_out_n == 1'b0, "R3 asynchronous assertion", int'(rst_out_n), 0);
      cyc(5);
      expect_evt(1); expect_len(H + 3, "R1 hold length after collapse");
      lo = 1'b1; hi = 1'b1;
      cyc(H + 10);

      // R2: release level arrives 30 cycles late
      lo = 1'b0; hi = 1'b0; cyc(3);
      expect_evt(1); expect_len(30 + 1 + H, "R2 delayed release level");
      lo = 1'b1; cyc(30); hi = 1'b1;
      cyc(H + 10);

      // R3: collapse during hold-off restarts the sequence
      lo = 1'b0; hi = 1'b0; cyc(3);
      expect_evt(1);
      lo = 1'b1; hi = 1'b1; cyc(10);
      lo = 1'b0; hi = 1'b0;
      #1;
      chk(rst_out_n == 1'b0, "R3 collapse in hold-off", int'(rst_out_n), 0);
      cyc(3);
      expect_evt(1); expect_len(H + 3, "R3 full hold after restart");
      lo = 1'b1; hi = 1'b1;
      cyc(H + 10);
      chk(rst_out_n == 1'b1, "R9 released at end", int'(rst_out_n), 1);

      chk(cause_q.size() == 0, "R8 all expected events seen", cause_q.size(), 0);
      chk(len_q.size() == 0, "R1 all expected releases seen", len_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule